// File: doc/BRIEF.md
# Overflow Interrupt Enable and Status Controller

This block gathers single-cycle overflow pulses from a bank of event counters and keeps each one as a sticky flag until software clears it. There are two source groups: sixteen general-purpose counters and eight bandwidth counters. A per-source enable mask decides which flags may raise the single level-sensitive interrupt line. Flags latch whether or not their source is enabled, so software can poll sources that are masked.

Software sees five word addresses on a small register port with a 12-bit byte address, 32-bit data and one cycle of read latency. One address sets enable bits and another clears them. In both, a one bit acts on its position and a zero bit leaves it alone. A third address returns the current mask. The flags are read at one address and cleared by writing ones to another. Only bits 23:0 exist. The upper byte always reads zero and ignores writes.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: After reset every enable bit and every status bit is zero, `irq` is low and `reg_rdata` is zero.
- R2: A write to byte address 0xCB8 sets each enable bit whose write-data bit is one. Enable bits whose write-data bit is zero keep their value.
- R3: A write to byte address 0xCBC clears each enable bit whose write-data bit is one. The other enable bits keep their value.
- R4: A read of byte address 0xCC0 returns the enable mask in bits 23:0.
- R5: A read of byte address 0xCC8 returns the sticky status in bits 23:0. General source i (`gen_ovf[i]`) maps to bit 8+i and bandwidth source j (`bw_ovf[j]`) maps to bit j. A pulse sets its bit whether or not that bit is enabled, and the bit stays set until it is cleared.
- R6: A write to byte address 0xCC4 clears each status bit whose write-data bit is one. Writing 0x00FFFFFF clears every status bit.
- R7: When a source pulse and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R8: `irq` is high exactly while at least one status bit and its matching enable bit are both set. It follows the register state with no added delay.
- R9: Read data appears on `reg_rdata` in the cycle after `reg_rd_en` and holds until the next read. An address outside the five listed reads zero. Writes to 0xCC0, to 0xCC8 or to any unmapped address change nothing.
- R10: Bits 31:24 of every read are zero. Write-data bits 31:24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_rd_en | input | 1 | Read strobe for the register port |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| gen_ovf | input | 16 | Overflow pulses from the general counters |
| bw_ovf | input | 8 | Overflow pulses from the bandwidth counters |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets four corner cases:

- A pulse and a write-one-to-clear that land on the same bit in the same cycle. A design that lets the clear win would silently lose an overflow.
- A pulse on a source that is masked. A design that gates the flag with the enable would show nothing in status, and `irq` would stay low after the source is later enabled.
- Writes with zeros in the set and clear registers, with upper-byte data, and to read-only or unmapped addresses. A sloppy decoder would disturb mask bits it should leave alone or leak bits into 31:24.
- The bit placement of the two source groups. A swapped group would show up as a readback offset by eight positions.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

    // Byte offsets of the register port
    localparam logic [11:0] OFS_EN_SET  = 12'hCB8;
    localparam logic [11:0] OFS_EN_CLR  = 12'hCBC;
    localparam logic [11:0] OFS_EN_VIEW = 12'hCC0;
    localparam logic [11:0] OFS_ST_W1C  = 12'hCC4;
    localparam logic [11:0] OFS_ST_VIEW = 12'hCC8;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_EN   = 2'd1,
        RSEL_ST   = 2'd2
    } rsel_e;

endpackage

// File: rtl/ovf_status_bank.sv
module ovf_status_bank #(
    parameter int NSRC = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic            w1c_we,
    input  logic [NSRC-1:0] w1c_mask,
    output logic [NSRC-1:0] flags
);
    typedef struct packed {
        logic [NSRC-1:0] flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            // a pulse in the same cycle as a clear wins
            if (src_pulse[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (w1c_we && w1c_mask[i]) begin
                st_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;
endmodule

// File: rtl/ovf_enable_mask.sv
module ovf_enable_mask #(
    parameter int NSRC = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [NSRC-1:0] wmask,
    output logic [NSRC-1:0] enables
);
    typedef struct packed {
        logic [NSRC-1:0] en;
    } msk_t;

    msk_t msk_d, msk_q;

    always_comb begin
        msk_d = msk_q;
        if (set_we) begin
            msk_d.en = msk_q.en | wmask;
        end else if (clr_we) begin
            msk_d.en = msk_q.en & ~wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_q <= '0;
        end else begin
            msk_q <= msk_d;
        end
    end

    assign enables = msk_q.en;
endmodule

// File: rtl/ovf_reg_port.sv
module ovf_reg_port
    import ovf_irq_pkg::*;
#(
    parameter int NSRC   = 24,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   en_view,
    input  logic [NSRC-1:0]   st_view,
    output logic              en_set_we,
    output logic              en_clr_we,
    output logic              st_w1c_we,
    output logic [NSRC-1:0]   wmask,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - NSRC;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t   rd_d, rd_q;
    rsel_e rsel;

    // write decode: only the implemented low bits reach the storage
    assign wmask     = wdata[NSRC-1:0];
    assign en_set_we = wr_en && (addr == ADDR_W'(OFS_EN_SET));
    assign en_clr_we = wr_en && (addr == ADDR_W'(OFS_EN_CLR));
    assign st_w1c_we = wr_en && (addr == ADDR_W'(OFS_ST_W1C));

    always_comb begin
        if (addr == ADDR_W'(OFS_EN_VIEW)) begin
            rsel = RSEL_EN;
        end else if (addr == ADDR_W'(OFS_ST_VIEW)) begin
            rsel = RSEL_ST;
        end else begin
            rsel = RSEL_NONE;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            unique case (rsel)
                RSEL_EN: rd_d.data = {{PAD_W{1'b0}}, en_view};
                RSEL_ST: rd_d.data = {{PAD_W{1'b0}}, st_view};
                default: rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;
endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl #(
    parameter int GEN_SRC = 16,
    parameter int BW_SRC  = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [GEN_SRC-1:0] gen_ovf,
    input  logic [BW_SRC-1:0]  bw_ovf,
    output logic              irq
);
    localparam int NSRC = GEN_SRC + BW_SRC;

    logic [NSRC-1:0] src_all;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] wmask;
    logic            en_set_we, en_clr_we, st_w1c_we;

    // bandwidth sources in the low bits, general sources above them
    for (genvar j = 0; j < BW_SRC; j++) begin : g_bw_map
        assign src_all[j] = bw_ovf[j];
    end
    for (genvar i = 0; i < GEN_SRC; i++) begin : g_gen_map
        assign src_all[BW_SRC+i] = gen_ovf[i];
    end

    ovf_reg_port #(
        .NSRC  (NSRC),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .en_view  (en_q),
        .st_view  (status_q),
        .en_set_we(en_set_we),
        .en_clr_we(en_clr_we),
        .st_w1c_we(st_w1c_we),
        .wmask    (wmask),
        .rdata    (reg_rdata)
    );

    ovf_enable_mask #(.NSRC(NSRC)) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (en_set_we),
        .clr_we (en_clr_we),
        .wmask  (wmask),
        .enables(en_q)
    );

    ovf_status_bank #(.NSRC(NSRC)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pulse(src_all),
        .w1c_we   (st_w1c_we),
        .w1c_mask (wmask),
        .flags    (status_q)
    );

    assign irq = |(status_q & en_q);
endmodule

// File: rtl/ovf_irq_ctrl_chk.sv
module ovf_irq_ctrl_chk #(
    parameter int GEN_SRC = 16,
    parameter int BW_SRC  = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [GEN_SRC-1:0] gen_ovf,
    input logic [BW_SRC-1:0]  bw_ovf,
    input logic [GEN_SRC+BW_SRC-1:0] status,
    input logic [GEN_SRC+BW_SRC-1:0] enable
);
    import ovf_irq_pkg::*;
    localparam int NSRC = GEN_SRC + BW_SRC;

    logic [NSRC-1:0] srcv;
    logic [NSRC-1:0] wlow;
    logic            wr_set, wr_clr, wr_w1c;
    assign srcv   = {gen_ovf, bw_ovf};
    assign wlow   = reg_wdata[NSRC-1:0];
    assign wr_set = reg_wr_en && (reg_addr == ADDR_W'(OFS_EN_SET));
    assign wr_clr = reg_wr_en && (reg_addr == ADDR_W'(OFS_EN_CLR));
    assign wr_w1c = reg_wr_en && (reg_addr == ADDR_W'(OFS_ST_W1C));

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((enable & $past(wlow)) == $past(wlow)));

    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((enable & $past(wlow)) == '0));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (srcv != '0) |=> ((status & $past(srcv)) == $past(srcv)));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_w1c |=> ((status & $past(status)) == $past(status)));

    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1c |=> ((status & $past(wlow & ~srcv)) == '0));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NSRC] == '0);
endmodule

bind ovf_irq_ctrl ovf_irq_ctrl_chk #(
    .GEN_SRC(GEN_SRC),
    .BW_SRC (BW_SRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .gen_ovf  (gen_ovf),
    .bw_ovf   (bw_ovf),
    .status   (status_q),
    .enable   (en_q)
);

// File: tb/ovf_irq_ctrl_tb.sv
module ovf_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] gen_ovf = '0;
    logic [7:0]  bw_ovf = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ovf_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gen_ovf(gen_ovf), .bw_ovf(bw_ovf), .irq(irq)
    );

    // behavioural reference model
    logic [23:0] m_en, m_st;
    logic [31:0] m_rd;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 0; m_st <= 0; m_rd <= 0;
        end else begin
            logic [23:0] srcs, nst, nen;
            srcs = {gen_ovf, bw_ovf};
            nst = m_st; nen = m_en;
            if (reg_wr_en) begin
                if (reg_addr == 12'hCB8) nen = m_en | reg_wdata[23:0];
                if (reg_addr == 12'hCBC) nen = m_en & ~reg_wdata[23:0];
                if (reg_addr == 12'hCC4) nst = m_st & ~reg_wdata[23:0];
            end
            nst = nst | srcs;
            if (reg_rd_en) begin
                if (reg_addr == 12'hCC0) m_rd <= {8'h0, m_en};
                else if (reg_addr == 12'hCC8) m_rd <= {8'h0, m_st};
                else m_rd <= 32'h0;
            end
            m_en <= nen; m_st <= nst;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== |(m_st & m_en)) begin
                errors++;
                $display("FAIL R8 irq actual=%0b expected=%0b", irq, |(m_st & m_en));
            end
            checks++;
            if (reg_rdata !== m_rd) begin
                errors++;
                $display("FAIL R9 rdata actual=%h expected=%h", reg_rdata, m_rd);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0; reg_wdata = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_rd_en = 1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 0;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse(logic [15:0] g, logic [7:0] b);
        @(negedge clk);
        gen_ovf = g; bw_ovf = b;
        @(negedge clk);
        gen_ovf = 0; bw_ovf = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata at reset", reg_rdata, 0);
        chk("R1 irq at reset", {31'h0, irq}, 0);
        rst_n = 1;
        rd(12'hCC8, 32'h0, "R1 status");
        rd(12'hCC0, 32'h0, "R1 enable");
        // masked source still latches (R5), no interrupt (R8)
        pulse(16'h0008, 8'h00);
        rd(12'hCC8, 32'h0000_0800, "R5 masked gen3");
        chk("R8 masked irq low", {31'h0, irq}, 0);
        wr(12'hCB8, 32'h0000_0800);
        chk("R8 irq after enable", {31'h0, irq}, 1);
        rd(12'hCC0, 32'h0000_0800, "R2 set");
        wr(12'hCB8, 32'hFF00_0001);
        rd(12'hCC0, 32'h0000_0801, "R10 upper ignored R2 zeros keep");
        wr(12'hCBC, 32'h0000_0800);
        rd(12'hCC0, 32'h0000_0001, "R3 clear");
        chk("R3 irq drops", {31'h0, irq}, 0);
        pulse(16'h0000, 8'h01);
        chk("R5 bw0 irq", {31'h0, irq}, 1);
        rd(12'hCC8, 32'h0000_0801, "R5 bw0 at bit0");
        wr(12'hCC4, 32'h0000_0001);
        rd(12'hCC8, 32'h0000_0800, "R6 w1c one bit");
        pulse(16'h0020, 8'h00);
        // simultaneous clear and pulse on bit 13
        @(negedge clk);
        reg_wr_en = 1; reg_addr = 12'hCC4; reg_wdata = 32'h0000_2000; gen_ovf = 16'h0020;
        @(negedge clk);
        reg_wr_en = 0; reg_wdata = 0; gen_ovf = 0;
        rd(12'hCC8, 32'h0000_2800, "R7 pulse beats clear");
        wr(12'hCC8, 32'h0);
        wr(12'hCC0, 32'h00FF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'hCC8, 32'h0000_2800, "R9 ro status write");
        rd(12'hCC0, 32'h0000_0001, "R9 ro enable write");
        rd(12'h004, 32'h0, "R9 unmapped read");
        repeat (3) @(negedge clk);
        chk("R9 rdata holds", reg_rdata, 32'h0);
        wr(12'hCC4, 32'h00FF_FFFF);
        rd(12'hCC8, 32'h0, "R6 clear all");
        pulse(16'hFFFF, 8'hFF);
        rd(12'hCC8, 32'h00FF_FFFF, "R5 all sources");
        chk("R8 irq all", {31'h0, irq}, 1);
        wr(12'hCBC, 32'h0000_0001);
        chk("R8 irq none enabled", {31'h0, irq}, 0);
        wr(12'hCB8, 32'h0000_0100);
        chk("R4 gen0 enabled irq", {31'h0, irq}, 1);
        rd(12'hCC0, 32'h0000_0100, "R4 readback");
        wr(12'hCC4, 32'h0000_FF00);
        rd(12'hCC8, 32'h00FF_00FF, "R6 partial clear");
        chk("R8 irq after partial", {31'h0, irq}, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule